// File: doc/BRIEF.md
# Gain-Hopping Charge Pump Controller

This block is the digital control loop for a switched-capacitor charge pump that offers seven fractional voltage gains. It runs on the control clock, nominally 1 MHz. On every edge it samples a one-bit regulation comparator. If the comparator reports that the regulated output is below its reference, the block commands the pump to deliver charge for the next cycle. Otherwise it commands a skip, and the pump rests.

A saturating up/down counter measures how often pumping is requested. It starts at the centre of its range. Pump cycles move it up and skip cycles move it down. Reaching the top of the range asks for one step more gain. Reaching the bottom asks for one step less. After either request the counter goes back to the centre. The gain index moves only on clock edges. It never drops below a minimum index supplied from outside, which is the lowest ratio that still keeps current from flowing back into the battery.

Each selected gain is applied over the pump's two switching phases. The phase generator that does this lies outside the block.

Top module: `gain_hop_ctrl`

## Requirements
- R1: `pump_en` after a clock edge equals the `cmp_low` sampled at that edge: 1 means pump (output below reference), 0 means skip. The latency is exactly one cycle.
- R2: `gain_idx` encodes the ratios 0=1/2, 1=2/3, 2=3/4, 3=1, 4=4/3, 5=3/2, 6=2, and it never exceeds 6.
- R3: With the density counter at its centre, seven consecutive pump samples raise `gain_idx` by one on the seventh edge and recentre the counter. Fewer than seven leave the gain unchanged.
- R4: With the density counter at its centre, eight consecutive skip samples lower `gain_idx` by one on the eighth edge and recentre the counter.
- R5: `gain_idx` is never below `min_idx` (with `min_idx` limited to 6). If `min_idx` rises above the current index, `gain_idx` equals it after the next edge.
- R6: Synchronous active-high `rst` sets `gain_idx` to the limited `min_idx`, clears `pump_en` and recentres the counter, so that exactly seven pumps after reset raise the gain.
- R7: A `min_idx` of 7 acts as 6. A raise request at index 6 leaves the index at 6.
- R8: A lower request while `gain_idx` equals the floor leaves the index at the floor, including at floor 0.
- R9: Strictly alternating pump and skip samples never change `gain_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_low | input | 1 | Comparator: 1 = output below reference |
| min_idx | input | 3 | Minimum permitted gain index |
| gain_idx | output | 3 | Selected gain ratio index |
| pump_en | output | 1 | 1 = pump this cycle, 0 = skip |

## Verification
Every result appears one register stage after its cause. `pump_en` reflects the comparator sample taken at the previous edge. A gain step shows on the same edge on which the counter reaches its limit, so the step lands on the seventh pump or the eighth skip counted from centre. A raised floor is applied after one edge. The bench changes inputs on the falling edge and reads the outputs just after the following rising edge. Each expected value therefore belongs to exactly one sampled input, and runs of sub-threshold length are checked on the cycle just before a step must occur.

// File: rtl/gh_pkg.sv
package gh_pkg;

    localparam int NUM_GAINS = 7;
    localparam int GAIN_W    = $clog2(NUM_GAINS);

    typedef logic [GAIN_W-1:0] gidx_t;

    // Ratio order matters: a larger index always means a larger ratio.
    typedef enum logic [GAIN_W-1:0] {
        RATIO_1_2 = 3'd0,
        RATIO_2_3 = 3'd1,
        RATIO_3_4 = 3'd2,
        RATIO_1_1 = 3'd3,
        RATIO_4_3 = 3'd4,
        RATIO_3_2 = 3'd5,
        RATIO_2_1 = 3'd6
    } ratio_e;

    localparam gidx_t GIDX_TOP = gidx_t'(RATIO_2_1);

    typedef struct packed {
        logic raise;
        logic lower;
    } hop_req_t;

    function automatic gidx_t cap_idx(gidx_t v);
        return (v > GIDX_TOP) ? GIDX_TOP : v;
    endfunction

endpackage

// File: rtl/gh_density_counter.sv
module gh_density_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pump_req,
    output gh_pkg::hop_req_t hop
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_step;

    // Saturating step, then compare against the two limits.
    always_comb begin
        if (pump_req)
            cnt_step = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
        else
            cnt_step = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
        hop.raise = (cnt_step == CNT_TOP);
        hop.lower = (cnt_step == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_MID;
        else if (hop.raise || hop.lower)
            cnt_q <= CNT_MID;
        else
            cnt_q <= cnt_step;
    end

    // R3/R4: every request is followed by a recentred counter
    p_recentre_r3: assert property (@(posedge clk) disable iff (rst)
        (hop.raise || hop.lower) |=> cnt_q == CNT_MID);

    // R3: the stored count never rests on a limit
    p_interior_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q != '0) && (cnt_q != CNT_TOP));

endmodule

// File: rtl/gh_gain_select.sv
module gh_gain_select (
    input  logic             clk,
    input  logic             rst,
    input  gh_pkg::hop_req_t hop,
    input  gh_pkg::gidx_t    floor_raw,
    output gh_pkg::gidx_t    gain_q
);
    import gh_pkg::*;

    gidx_t floor_c;
    gidx_t stepped;
    gidx_t gain_d;

    always_comb begin
        floor_c = cap_idx(floor_raw);
        stepped = gain_q;
        if (hop.raise && (gain_q < GIDX_TOP))
            stepped = gain_q + 1'b1;
        else if (hop.lower && (gain_q != '0))
            stepped = gain_q - 1'b1;
        gain_d = (stepped < floor_c) ? floor_c : stepped;
    end

    always_ff @(posedge clk) begin
        if (rst)
            gain_q <= floor_c;
        else
            gain_q <= gain_d;
    end

    // R2: index stays inside the seven legal ratios
    p_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> gain_q <= GIDX_TOP);

    // R5: index respects the floor seen at the previous edge
    p_floor_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> gain_q >= cap_idx($past(floor_raw)));

    // R3: an unblocked raise request steps up by exactly one
    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (hop.raise && (gain_q < GIDX_TOP) && (cap_idx(floor_raw) <= gain_q))
        |=> gain_q == $past(gain_q) + 1'b1);

    // R8: a lower request at the floor holds the index
    p_floor_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (hop.lower && (gain_q == cap_idx(floor_raw)))
        |=> gain_q == $past(gain_q));

endmodule

// File: rtl/gain_hop_ctrl.sv
module gain_hop_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_low,
    input  logic [2:0] min_idx,
    output logic [2:0] gain_idx,
    output logic       pump_en
);
    import gh_pkg::*;

    hop_req_t hop;
    gidx_t    gain_w;

    gh_density_counter #(.CNT_W(CNT_W)) u_density (
        .clk      (clk),
        .rst      (rst),
        .pump_req (cmp_low),
        .hop      (hop)
    );

    gh_gain_select u_select (
        .clk       (clk),
        .rst       (rst),
        .hop       (hop),
        .floor_raw (gidx_t'(min_idx)),
        .gain_q    (gain_w)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pump_en <= 1'b0;
        else
            pump_en <= cmp_low;
    end

    assign gain_idx = gain_w;

    // R1: a new pump command must come from a low sample
    p_pump_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(pump_en) |-> $past(cmp_low));

    // R1: a skip command must come from a high sample
    p_pump_fall_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(pump_en) |-> !$past(cmp_low));

    // R6: reset leaves pump idle and gain on the limited floor
    p_reset_state_r6: assert property (@(posedge clk)
        rst |=> (!pump_en && gain_idx == cap_idx(gidx_t'($past(min_idx)))));

endmodule

// File: tb/gain_hop_ctrl_test.sv
module gain_hop_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_low = 1'b0;
    logic [2:0] min_idx = 3'd2;
    logic [2:0] gain_idx;
    logic       pump_en;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    gain_hop_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .cmp_low  (cmp_low),
        .min_idx  (min_idx),
        .gain_idx (gain_idx),
        .pump_en  (pump_en)
    );

    always #5 clk = ~clk;

    // Row: {cmp_low, min_idx[2:0], expected gain_idx[2:0], expected pump_en}
    localparam int NV = 27;
    localparam logic [7:0] VEC [NV] = '{
        8'b1_010_010_1, 8'b1_010_010_1, 8'b1_010_010_1,
        8'b1_010_010_1, 8'b1_010_010_1, 8'b1_010_010_1,
        8'b1_010_011_1,                                  // R3 seventh pump
        8'b0_010_011_0, 8'b1_010_011_1,
        8'b0_010_011_0, 8'b0_010_011_0, 8'b0_010_011_0,
        8'b0_010_011_0, 8'b0_010_011_0, 8'b0_010_011_0,
        8'b0_010_011_0,
        8'b0_010_010_0,                                  // R4 eighth skip
        8'b0_101_101_0,                                  // R5 floor jump
        8'b1_101_101_1,
        8'b0_000_101_0, 8'b0_000_101_0, 8'b0_000_101_0,
        8'b0_000_101_0, 8'b0_000_101_0, 8'b0_000_101_0,
        8'b0_000_101_0,
        8'b0_000_100_0                                   // R4 after floor drop
    };

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(logic c, logic [2:0] m);
        @(negedge clk);
        rst = 1'b0;
        cmp_low = c;
        min_idx = m;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(logic [2:0] m);
        @(negedge clk);
        rst = 1'b1;
        cmp_low = 1'b0;
        min_idx = m;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R6 reset state
        do_reset(3'd2);
        chk("R6 gain", gain_idx, 2);
        chk("R6 pump", pump_en, 0);

        // Table walk: R1, R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7], VEC[i][6:4]);
            chk($sformatf("R3/R4/R5 gain row %0d", i), gain_idx, VEC[i][3:1]);
            chk($sformatf("R1 pump row %0d", i), pump_en, VEC[i][0]);
        end

        // R7: floor 7 acts as 6, raise at top holds
        do_reset(3'd7);
        chk("R7 reset clamp", gain_idx, 6);
        for (int i = 0; i < 7; i++) step(1'b1, 3'd7);
        chk("R7 hold top", gain_idx, 6);
        chk("R2 max", gain_idx <= 3'd6, 1);

        // R8: lower at floor holds
        do_reset(3'd3);
        for (int i = 0; i < 8; i++) step(1'b0, 3'd3);
        chk("R8 floor 3", gain_idx, 3);
        do_reset(3'd0);
        for (int i = 0; i < 8; i++) step(1'b0, 3'd0);
        chk("R8 floor 0", gain_idx, 0);

        // R9: alternation never hops
        do_reset(3'd1);
        for (int i = 0; i < 40; i++) begin
            step(i % 2 == 0, 3'd1);
            chk("R9 alternate", gain_idx, 1);
        end

        // R6: reset recentres a partly filled counter
        do_reset(3'd1);
        for (int i = 0; i < 5; i++) step(1'b1, 3'd1);
        do_reset(3'd1);
        chk("R6 pump cleared", pump_en, 0);
        for (int i = 0; i < 6; i++) step(1'b1, 3'd1);
        chk("R6 six pumps", gain_idx, 1);
        step(1'b1, 3'd1);
        chk("R6 seventh pump", gain_idx, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule